// File: doc/BRIEF.md
# Video Line DMA Fetch Sequencer

This block fills a line buffer with packed pixel bytes ahead of each displayed row. When a line-start strobe arrives, it pulls its active-low bus-hold request low. It emits one seizure pulse on the strobe output; this pulse moves no data and gives the processor time to let go of the bus. Once the active-high hold acknowledge is high, the block reads the bytes of the current row one per clock. Each read is flagged on the read strobe, and the matching line-buffer slot is enabled. Every byte carries two horizontal pixels, one per nibble. Turning those bytes into pixels happens downstream and is not part of this block.

A mode bit picks the frame size. The small frame is 512 bytes: 16 bytes per row and 32 rows. The large frame is 2048 bytes: 32 bytes per row and 64 rows. So one row costs 17 strobe pulses in small mode and 33 in large mode. An internal row index advances after every fetched row, wraps at the row count of the frame, and returns to zero on a frame-start strobe. The memory address is the latched base plus the row's offset within the frame.

Top module: `vid_line_fetch`

## Requirements
- R1: During and right after reset, hold_req_n is 1, and rd_strobe, dma_strobe and every buf_we bit are 0.
- R2: A line_start seen while the block is idle drives hold_req_n to 0 in the next cycle. In that same cycle dma_strobe is 1 for a single cycle and rd_strobe is 0, so the seizure pulse carries no data.
- R3: rd_strobe is 1 in a cycle only if hold_ack was 1 at the clock edge that began that cycle. A late acknowledge makes the block wait.
- R4: With mode_large = 0, a line produces exactly 16 reads and 17 dma_strobe pulses.
- R5: With mode_large = 1, a line produces exactly 32 reads and 33 dma_strobe pulses.
- R6: Read k of row L has mem_addr = base + ((L*B + k) mod F), taken modulo 2^ADDR_W. B and F are 16 and 512 in small mode, and 32 and 2048 in large mode.
- R7: During read k, buf_we equals 1 << k (bit k set, bit 0 first). In every other cycle buf_we is all zero.
- R8: hold_req_n returns to 1 exactly one cycle after the cycle of the last read.
- R9: The row index starts at 0, rises by 1 after each fetched row, and wraps to 0 after row 31 in small mode and after row 63 in large mode. A frame_start strobe sets it to 0.
- R10: mode_large and base_addr are captured at line start, so changing them during a line has no effect on that line. A line_start that arrives while a line is in progress is ignored.
- R11: If hold_ack falls during a burst, reads stop and then resume at the same byte once it rises again. No byte is skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Starts fetching the next row |
| frame_start | input | 1 | Resets the row index to zero |
| mode_large | input | 1 | 0: 16 bytes per row in a 512-byte frame; 1: 32 bytes per row in a 2048-byte frame |
| base_addr | input | ADDR_W | Start address of the frame |
| hold_ack | input | 1 | Active-high grant of the bus |
| hold_req_n | output | 1 | Active-low bus request |
| dma_strobe | output | 1 | Pulse train: one seizure pulse, then one pulse per read |
| rd_strobe | output | 1 | Memory read this cycle |
| mem_addr | output | ADDR_W | Memory read address |
| buf_we | output | LARGE_BYTES | One-hot line-buffer write enable |

## Verification
The hardest case to reach from the ports is an acknowledge that drops in the middle of a burst. For that case the bench must show two things: no read is issued while the grant is gone, and the address sequence picks up again at the byte where it stopped. The bench models the processor's response. It raises hold_ack a varying number of cycles after the request falls, and it pulls hold_ack low for three cycles after a chosen read number, which differs from row to row. The bench sweeps every row of both frame sizes, including the wrap of the row index. During each line it also scrambles the mode and base inputs and repeats line_start, so it can show those inputs are ignored while a line is in progress.

// File: rtl/vlf_pkg.sv
package vlf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEIZE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_FETCH = 3'd3,
    ST_REL   = 3'd4
  } vlf_state_t;
endpackage

// File: rtl/vlf_byte_ctr.sv
module vlf_byte_ctr #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  // R11: the counter only moves when told to, so a paused burst keeps its byte
  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr) && !$past(inc)) |-> $stable(cnt));
endmodule

// File: rtl/vlf_line_ctr.sv
module vlf_line_ctr #(
  parameter int SMALL_LINES = 32,
  parameter int LARGE_LINES = 64,
  localparam int LW = $clog2(LARGE_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          adv,
  input  logic          mode_large,
  output logic [LW-1:0] line_idx
);
  logic [LW-1:0] limit;
  assign limit = mode_large ? LW'(LARGE_LINES - 1) : LW'(SMALL_LINES - 1);

  always_ff @(posedge clk) begin
    if (rst || frame_start)  line_idx <= '0;
    else if (adv)            line_idx <= (line_idx >= limit) ? '0 : line_idx + 1'b1;
  end

  // R9: a frame start always clears the row index
  a_r9_frame_clear: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (line_idx == '0));
endmodule

// File: rtl/vlf_addr_gen.sv
module vlf_addr_gen #(
  parameter int ADDR_W      = 16,
  parameter int SMALL_BYTES = 16,
  parameter int LARGE_BYTES = 32,
  parameter int SMALL_LINES = 32,
  parameter int LARGE_LINES = 64,
  localparam int LW = $clog2(LARGE_LINES),
  localparam int CW = $clog2(LARGE_BYTES),
  localparam int OW = $clog2(LARGE_BYTES * LARGE_LINES)
) (
  input  logic              mode_large,
  input  logic [ADDR_W-1:0] base,
  input  logic [LW-1:0]     line_idx,
  input  logic [CW-1:0]     byte_idx,
  output logic [ADDR_W-1:0] addr
);
  logic [OW-1:0] bpl, mask, off;

  assign bpl  = mode_large ? OW'(LARGE_BYTES) : OW'(SMALL_BYTES);
  assign mask = mode_large ? OW'(LARGE_BYTES * LARGE_LINES - 1)
                           : OW'(SMALL_BYTES * SMALL_LINES - 1);
  assign off  = (OW'(line_idx) * bpl + OW'(byte_idx)) & mask;
  assign addr = base + ADDR_W'(off);
endmodule

// File: rtl/vid_line_fetch.sv
module vid_line_fetch #(
  parameter int ADDR_W      = 16,
  parameter int SMALL_BYTES = 16,
  parameter int LARGE_BYTES = 32,
  parameter int SMALL_LINES = 32,
  parameter int LARGE_LINES = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   line_start,
  input  logic                   frame_start,
  input  logic                   mode_large,
  input  logic [ADDR_W-1:0]      base_addr,
  input  logic                   hold_ack,
  output logic                   hold_req_n,
  output logic                   dma_strobe,
  output logic                   rd_strobe,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [LARGE_BYTES-1:0] buf_we
);
  import vlf_pkg::*;

  localparam int CW = $clog2(LARGE_BYTES);
  localparam int LW = $clog2(LARGE_LINES);

  vlf_state_t        state;
  logic              mode_q;
  logic [ADDR_W-1:0] base_q;
  logic [CW-1:0]     byte_idx;
  logic [LW-1:0]     line_idx;
  logic [ADDR_W-1:0] addr_nx;
  logic              last_byte, start, fetch_go, byte_clr, byte_inc, line_adv;
  logic [LARGE_BYTES-1:0] we_nx;

  assign start     = (state == ST_IDLE) && line_start;
  assign fetch_go  = (state == ST_FETCH) && hold_ack;
  assign last_byte = mode_q ? (byte_idx == CW'(LARGE_BYTES - 1))
                            : (byte_idx == CW'(SMALL_BYTES - 1));
  assign byte_clr  = start;
  assign byte_inc  = fetch_go && !last_byte;
  assign line_adv  = (state == ST_REL);
  assign we_nx     = {{(LARGE_BYTES-1){1'b0}}, 1'b1} << byte_idx;

  vlf_byte_ctr #(.CW(CW)) u_byte (
    .clk(clk), .rst(rst), .clr(byte_clr), .inc(byte_inc), .cnt(byte_idx)
  );

  vlf_line_ctr #(.SMALL_LINES(SMALL_LINES), .LARGE_LINES(LARGE_LINES)) u_line (
    .clk(clk), .rst(rst), .frame_start(frame_start), .adv(line_adv),
    .mode_large(mode_q), .line_idx(line_idx)
  );

  vlf_addr_gen #(
    .ADDR_W(ADDR_W), .SMALL_BYTES(SMALL_BYTES), .LARGE_BYTES(LARGE_BYTES),
    .SMALL_LINES(SMALL_LINES), .LARGE_LINES(LARGE_LINES)
  ) u_addr (
    .mode_large(mode_q), .base(base_q), .line_idx(line_idx),
    .byte_idx(byte_idx), .addr(addr_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      hold_req_n <= 1'b1;
      dma_strobe <= 1'b0;
      rd_strobe  <= 1'b0;
      buf_we     <= '0;
      mem_addr   <= '0;
      mode_q     <= 1'b0;
      base_q     <= '0;
    end else begin
      dma_strobe <= 1'b0;
      rd_strobe  <= 1'b0;
      buf_we     <= '0;
      case (state)
        ST_IDLE: if (line_start) begin
          mode_q     <= mode_large;
          base_q     <= base_addr;
          hold_req_n <= 1'b0;
          dma_strobe <= 1'b1;
          state      <= ST_SEIZE;
        end
        ST_SEIZE: state <= ST_WAIT;
        ST_WAIT:  if (hold_ack) state <= ST_FETCH;
        ST_FETCH: if (fetch_go) begin
          rd_strobe  <= 1'b1;
          dma_strobe <= 1'b1;
          mem_addr   <= addr_nx;
          buf_we     <= we_nx;
          if (last_byte) state <= ST_REL;
        end
        ST_REL: begin
          hold_req_n <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a read only follows a sampled grant
  a_r3_read_needs_ack: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |-> $past(hold_ack));
  // R7: write enables are one-hot and only present with a read
  a_r7_we_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(buf_we) && (rd_strobe == (buf_we != '0)));
  // R2: the request falls together with a data-free seizure pulse
  a_r2_seize_no_data: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_req_n) |-> (dma_strobe && !rd_strobe));
  // R8: the request is released right after the last read
  a_r8_release_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_req_n) |-> $past(rd_strobe));
  // R4: small mode never indexes past its row length
  a_r4_small_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && !mode_q) |-> (byte_idx < CW'(SMALL_BYTES)));
  // R2: strobe pulses only occur while the bus is requested
  a_r2_strobe_in_hold: assert property (@(posedge clk) disable iff (rst)
    dma_strobe |-> !hold_req_n);
endmodule

// File: tb/tb_vid_line_fetch.sv
module tb_vid_line_fetch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_start = 1'b0, frame_start = 1'b0, mode_large = 1'b0, hold_ack = 1'b0;
  logic [15:0] base_addr = '0;
  logic        hold_req_n, dma_strobe, rd_strobe;
  logic [15:0] mem_addr;
  logic [31:0] buf_we;

  int errors = 0, checks = 0, exp_line = 0;

  always #4 clk = ~clk;

  vid_line_fetch dut (
    .clk(clk), .rst(rst), .line_start(line_start), .frame_start(frame_start),
    .mode_large(mode_large), .base_addr(base_addr), .hold_ack(hold_ack),
    .hold_req_n(hold_req_n), .dma_strobe(dma_strobe), .rd_strobe(rd_strobe),
    .mem_addr(mem_addr), .buf_we(buf_we)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_line(input bit m, input logic [15:0] b, input int delay, input int drop_at);
    int bpl, frame, lines, reads, pulses, cyc, last_rd, drop_left;
    bit prev_ack, done, dropped;
    logic [15:0] ea;
    bpl = m ? 32 : 16; frame = m ? 2048 : 512; lines = m ? 64 : 32;
    @(negedge clk);
    line_start = 1'b1; mode_large = m; base_addr = b; hold_ack = 1'b0;
    @(negedge clk);
    line_start = 1'b0;
    chk(!hold_req_n && dma_strobe && !rd_strobe, "R2 seize pulse",
        {hold_req_n, dma_strobe, rd_strobe}, 3'b010);
    mode_large = ~m; base_addr = ~b;   // R10: must be ignored this line
    hold_ack = (delay == 0); prev_ack = hold_ack;
    reads = 0; pulses = 1; cyc = 0; done = 0; dropped = 0; drop_left = 0; last_rd = -1;
    while (!done && cyc < 400) begin
      @(negedge clk); cyc++;
      if (rd_strobe) begin
        chk(prev_ack, "R3 read without ack", rd_strobe, 0);
        ea = b + 16'(((exp_line * bpl) + reads) % frame);
        chk(mem_addr == ea, "R6/R10/R11 address", mem_addr, ea);
        chk(buf_we == (32'd1 << reads), "R7 write enable", buf_we, 32'd1 << reads);
        reads++; last_rd = cyc;
      end else if (buf_we != 0) begin
        chk(0, "R7 stray enable", buf_we, 0);
      end
      if (dma_strobe) pulses++;
      if (hold_req_n) begin
        done = 1;
        chk(last_rd == cyc - 1, "R8 release timing", cyc - last_rd, 1);
      end
      line_start = (cyc == 2);   // R10: busy start ignored
      if (!dropped && drop_at > 0 && reads == drop_at) begin drop_left = 3; dropped = 1; end
      hold_ack = (cyc >= delay) && (drop_left == 0);
      if (drop_left > 0) drop_left--;
      prev_ack = hold_ack;
    end
    chk(reads == bpl, m ? "R5 read count" : "R4 read count", reads, bpl);
    chk(pulses == bpl + 1, m ? "R5 pulse count" : "R4 pulse count", pulses, bpl + 1);
    hold_ack = 1'b0; line_start = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(hold_req_n && !rd_strobe && !dma_strobe, "R10 no extra burst",
          {hold_req_n, rd_strobe, dma_strobe}, 3'b100);
    end
    exp_line = (exp_line >= lines - 1) ? 0 : exp_line + 1;   // R9
  endtask

  task automatic pulse_frame;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    exp_line = 0;   // R9
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(hold_req_n && !rd_strobe && !dma_strobe && buf_we == 0, "R1 in reset",
        {hold_req_n, rd_strobe, dma_strobe}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    chk(hold_req_n && !rd_strobe && !dma_strobe && buf_we == 0, "R1 after reset",
        {hold_req_n, rd_strobe, dma_strobe}, 3'b100);
    for (int i = 0; i < 34; i++)
      run_line(1'b0, 16'h4000 + 16'(i * 7), i % 4, (i % 3 == 0) ? (i % 15) + 1 : 0);
    pulse_frame();
    for (int i = 0; i < 66; i++)
      run_line(1'b1, (i % 5 == 0) ? 16'hFC00 : 16'h8000, i % 5, (i % 2 == 0) ? (i % 31) + 1 : 0);
    run_line(1'b0, 16'h1234, 2, 5);
    pulse_frame();
    run_line(1'b0, 16'h1234, 0, 15);
    run_line(1'b1, 16'hFFF0, 6, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule